// File: doc/BRIEF.md
# Suspend State Scan Chain

This block lets software save and restore the whole internal state of a sound-emulation engine across a power suspend. The engine's state is held as one serial chain of `CHAIN_LEN` bits, 268 by default. Software moves the chain through a byte-wide data port. Each access transfers eight bits. The chain length is not a multiple of eight, so the final access carries only the remaining bits.

Scanning is guarded by a handshake. Software first raises a power-down request. It then waits for the engine to acknowledge. Next it selects scan mode and a direction, and raises scan enable. For a save, the engine's live state is captured when the scan becomes active, and software then reads the bytes out. For a restore, software writes the bytes in. When the last bit has arrived, the block presents the rebuilt image to the engine with a one-cycle valid pulse.

A status register shows three things: the acknowledge, a done flag, and whether the FIFO that feeds the synthesizer is empty. A separate read-only register shows the synthesizer's current register index.

Top module: `scan_state_saver`

## Requirements
- R1: After reset, the control register reads 00h and every data-port read returns 00h. Status bit 7 reads 1 and the index register reads 00h.
- R2: Data-port accesses are ignored and reads return 00h unless all four of these hold: control bit 0 (power-down request), the acknowledge input, control bit 1 (scan mode) and control bit 3 (scan enable). The chain is not changed.
- R3: With direction bit 2 set to 1 (save), the engine state is captured when the scan becomes active. Read k returns chain bits 8k+7..8k, least significant bit first.
- R4: The 34th access of a save returns only the last 4 bits, in the low nibble, with the high nibble 0.
- R5: After all `CHAIN_LEN` bits have moved, status bit 1 (done) reads 1. Further data accesses return 00h and have no effect.
- R6: Done clears once scan enable (control bit 3) is written to 0.
- R7: With direction bit 2 set to 0 (restore), write k supplies chain bits 8k+7..8k, and the final write uses only its low 4 bits. In the cycle after the final write, restore valid is high for exactly one cycle, and the restore image equals the written bits.
- R8: Status bit 0 mirrors the acknowledge input. Status bit 7 shows the FIFO-empty input, delayed by one clock.
- R9: The index register (address 3) shows the synthesizer index input, delayed by one clock.
- R10: A data-port read during a restore returns 00h and does not shift the chain. A data-port write during a save is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 data |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (a data read shifts the chain) |
| rd_addr | input | 2 | Read address: 0 control, 1 data, 2 status, 3 index |
| rd_data | output | 8 | Read data, combinational |
| pd_req | output | 1 | Power-down request to the engine |
| pd_ack | input | 1 | Engine ready for suspend |
| eng_state | input | CHAIN_LEN | Live engine state, captured at the start of a save |
| fifo_empty | input | 1 | Synthesizer FIFO empty |
| syn_index | input | 8 | Current synthesizer register index |
| restore_valid | output | 1 | One-cycle pulse: the restore image is complete |
| restore_data | output | CHAIN_LEN | Restored state image |

## Verification
A wrong bit counter shows up at the data port as a short or truncated final byte. It can also show up as a done flag that rises too early or too late, and each of these is visible within the same save or restore sequence. A wrong shift direction or a stale chain corrupts the bytes read out, starting from the first or second byte after capture. A broken gate lets an ignored access consume bits, and the next honoured byte then comes back misaligned. Round trips with several distinct bit patterns expose each of these faults against values the bench computes arithmetically.

// File: rtl/scan_state_saver.sv
module scan_state_saver #(
  parameter int CHAIN_LEN = 268
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 rd_en,
  input  logic [1:0]           rd_addr,
  output logic [7:0]           rd_data,
  output logic                 pd_req,
  input  logic                 pd_ack,
  input  logic [CHAIN_LEN-1:0] eng_state,
  input  logic                 fifo_empty,
  input  logic [7:0]           syn_index,
  output logic                 restore_valid,
  output logic [CHAIN_LEN-1:0] restore_data
);
  localparam int CW = $clog2(CHAIN_LEN + 1);

  logic [3:0]           ctl;
  logic [CHAIN_LEN-1:0] chain;
  logic [CW-1:0]        cnt;
  logic                 done, act_q, fifo_q, rv_q;
  logic [7:0]           idx_q;

  logic dir_out, active, live, rd_hit, wr_hit;
  logic [CW-1:0] remain;
  logic [3:0]    step;
  logic [7:0]    out_byte;
  logic [CHAIN_LEN+7:0] in_ext;

  assign pd_req  = ctl[0];
  assign dir_out = ctl[2];
  assign active  = ctl[0] & pd_ack & ctl[1] & ctl[3];
  assign live    = active & act_q & ~done;
  assign rd_hit  = rd_en & (rd_addr == 2'd1) & live & dir_out;
  assign wr_hit  = wr_en & (wr_addr == 2'd1) & live & ~dir_out;
  assign remain  = CW'(CHAIN_LEN) - cnt;
  assign step    = (remain >= CW'(8)) ? 4'd8 : 4'(remain);
  assign out_byte = chain[7:0] & (8'hFF >> (4'd8 - step));
  assign in_ext  = {wr_data, chain} >> step;

  always_comb begin
    unique case (rd_addr)
      2'd0: rd_data = {4'b0, ctl};
      2'd1: rd_data = rd_hit ? out_byte : 8'h00;
      2'd2: rd_data = {fifo_q, 5'b0, done, pd_ack};
      default: rd_data = idx_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= '0;
      fifo_q <= 1'b1;
      idx_q  <= '0;
    end else begin
      fifo_q <= fifo_empty;
      idx_q  <= syn_index;
      if (wr_en && wr_addr == 2'd0) ctl <= wr_data[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      act_q <= 1'b0;
      rv_q  <= 1'b0;
    end else begin
      act_q <= active;
      rv_q  <= 1'b0;
      if (!ctl[3]) done <= 1'b0;
      if (!active) begin
        cnt <= '0;
      end else if (!act_q) begin
        cnt <= '0;
        if (dir_out) chain <= eng_state;
      end else if (rd_hit || wr_hit) begin
        chain <= rd_hit ? (chain >> step) : in_ext[CHAIN_LEN-1:0];
        cnt   <= cnt + CW'(step);
        if (cnt + CW'(step) == CW'(CHAIN_LEN)) begin
          done <= 1'b1;
          rv_q <= wr_hit;
        end
      end
    end
  end

  assign restore_valid = rv_q;
  assign restore_data  = chain;

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CHAIN_LEN));
  // R2
  no_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_ack |=> $stable(chain));
  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[3] |=> !done);
  // R7
  restore_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> (done && !dir_out));
  // R7
  restore_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> !restore_valid);
  // R10
  save_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && dir_out && !(rd_en && rd_addr == 2'd1)) |=> $stable(chain));
endmodule

// File: tb/scan_state_saver_bench.sv
module scan_state_saver_bench;
  localparam int L = 268;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data, syn_index = 0;
  logic pd_req, pd_ack = 0, fifo_empty = 0, restore_valid;
  logic [L-1:0] eng_state = '0, restore_data;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  scan_state_saver #(.CHAIN_LEN(L)) u_scan_state_saver (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr, .rd_data,
    .pd_req, .pd_ack, .eng_state, .fifo_empty, .syn_index,
    .restore_valid, .restore_data);

  task automatic chk(string req, logic [L-1:0] act, logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic logic [L-1:0] pattern(int s);
    logic [L-1:0] p;
    for (int i = 0; i < L; i++) p[i] = 1'(((i * i + s * i + s) >> 2) & 1);
    return p;
  endfunction

  task automatic start(logic [7:0] c);
    wr(0, 8'h01); pd_ack = 1; wr(0, c); @(negedge clk);
  endtask

  task automatic save_check(logic [L-1:0] p);
    logic [7:0] d;
    logic [L-1:0] sh;
    eng_state = p; start(8'h0F); eng_state = ~p;
    for (int k = 0; k < 34; k++) begin
      if (k == 5) begin
        wr(1, 8'hA5);
        rd(1, d); sh = p >> 40; chk("R10 save write ignored", L'(d), L'(sh[7:0]));
        continue;
      end
      rd(1, d);
      sh = p >> (8 * k);
      if (k == 33) chk("R4 final nibble", L'(d), L'(sh[3:0]));
      else chk("R3 save byte", L'(d), L'(sh[7:0]));
    end
    rd(2, d); chk("R5 done set", L'(d[1]), 1);
    rd(1, d); chk("R5 read after done", L'(d), 0);
    wr(0, 8'h07); rd(2, d); chk("R6 done cleared", L'(d[1]), 0);
    wr(0, 8'h00); pd_ack = 0;
  endtask

  task automatic restore_check(logic [L-1:0] p);
    logic [7:0] d;
    logic [L-1:0] sh;
    start(8'h0B);
    for (int k = 0; k < 34; k++) begin
      sh = p >> (8 * k);
      if (k == 3) begin
        rd(1, d); chk("R10 restore read", L'(d), 0);
      end
      if (k == 33) begin
        @(negedge clk); wr_en = 1; wr_addr = 1; wr_data = {4'hC, sh[3:0]};
        @(negedge clk); wr_en = 0;
        chk("R7 restore valid", L'(restore_valid), 1);
        chk("R7 restore image", restore_data, p);
        @(negedge clk); chk("R7 valid single", L'(restore_valid), 0);
      end else wr(1, sh[7:0]);
    end
    wr(1, 8'hFF); chk("R5 write after done", restore_data, p);
    wr(0, 8'h00); pd_ack = 0;
  endtask

  initial begin
    #200000; errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rd(0, d); chk("R1 control reset", L'(d), 0);
    rd(2, d); chk("R1 fifo reset", L'(d[7]), 1);
    rd(3, d); chk("R1 index reset", L'(d), 0);
    rd(1, d); chk("R1 data reset", L'(d), 0);
    rst_n = 1;
    fifo_empty = 0; syn_index = 8'h3C; @(negedge clk); @(negedge clk);
    rd(2, d); chk("R8 fifo status", L'(d[7]), 0);
    rd(3, d); chk("R9 index", L'(d), 8'h3C);
    pd_ack = 1; rd(2, d); chk("R8 ack status", L'(d[0]), 1); pd_ack = 0;
    eng_state = pattern(3);
    wr(0, 8'h0F); @(negedge clk);
    rd(1, d); chk("R2 no ack read", L'(d), 0);
    wr(0, 8'h00);
    wr(0, 8'h0F); pd_ack = 1; wr(0, 8'h0D); @(negedge clk);
    rd(1, d); chk("R2 no mode read", L'(d), 0);
    wr(0, 8'h00); pd_ack = 0;
    save_check(pattern(3));
    save_check(pattern(11));
    save_check({(L/2){2'b10}});
    save_check('1);
    restore_check(pattern(5));
    restore_check({(L/4){4'b0110}});
    restore_check(pattern(17));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule